// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the order of column addresses for one burst of a double-data-rate SDRAM-style memory. It has a small configuration port that selects one of four burst lengths (2, 4, 8 or 16 beats) and one of two orderings: a wrapping increment, or an XOR of the start offset with the beat number. A single start strobe captures a starting column. From the next cycle on, the block emits one column address per cycle until the burst is complete. A valid flag accompanies every address, and a last flag marks the final beat.

Every address of a burst stays inside the naturally aligned block of columns that holds the start address. That block is as large as the burst length. The bits above the block boundary are copied unchanged from the start column. The bits below it give the position of each beat inside the block. Read and write bursts share the same settings, and the ordering depends only on the length, the ordering mode and the start column. While a burst runs, both the configuration port and the start strobe are locked out, and a busy output shows this.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-high reset clears busy, valid and last and selects the defaults: 2-beat bursts in sequential order.
- R2: The first address appears in the cycle after an accepted start, and valid then stays high for exactly burst-length consecutive cycles. Busy equals valid.
- R3: Last is high only together with valid, on the final beat of each burst.
- R4: In sequential mode (type bit 0) the offset inside the block starts at the start column's low bits and counts up by one per beat, wrapping modulo the burst length. For example, length 8 from 5 gives 5,6,7,0,1,2,3,4.
- R5: In interleaved mode (type bit 1) the offset on beat i equals the start offset XOR i. For example, length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R6: The column bits at and above log2(burst length) equal the start column on every beat of the burst.
- R7: A start strobe while busy is high is ignored, and the running burst continues unchanged.
- R8: A configuration write while busy is high is ignored, and the next burst uses the earlier settings.
- R9: When a configuration write and a start arrive in the same idle cycle, the burst uses the settings in force before that cycle, and the new settings apply from the next burst on.
- R10: The length field encodes 00=2, 01=4, 10=8 and 11=16 beats, and each length works in both orderings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgLen | input | 2 | Burst length code |
| cfgType | input | 1 | Ordering: 0 sequential, 1 interleaved |
| start | input | 1 | Burst start strobe |
| startCol | input | COL_W | Starting column address |
| busy | output | 1 | Burst in progress; start and configuration locked |
| colValid | output | 1 | colAddr holds a beat address |
| colAddr | output | COL_W | Column address of the current beat |
| colLast | output | 1 | Current beat is the final one |

## Verification
Two operations can coincide on the same clock edge. A configuration write can meet a start while the block is idle, and a start or a configuration write can arrive in a cycle of a running burst, including its final beat. The bench raises the configuration write and the start together and expects the burst to follow the old settings and the next burst to follow the new ones. It also injects a start and a configuration write partway through a burst, and expects the address stream, the burst length and the later configuration to be unaffected. The main sweep covers every length, both orderings and all sixteen low start offsets, with random upper bits.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int MAX_BL = 16;
  localparam int BEAT_W = $clog2(MAX_BL);

  typedef enum logic [1:0] {
    LEN2  = 2'b00,
    LEN4  = 2'b01,
    LEN8  = 2'b10,
    LEN16 = 2'b11
  } burstLen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } burstOrd_e;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobes_t;

  function automatic logic [BEAT_W-1:0] lenMask(input burstLen_e len);
    logic [BEAT_W-1:0] m;
    m = '0;
    for (int b = 0; b < BEAT_W; b++) begin
      if (b <= int'(len)) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cfgWe,
  input  logic [1:0]   cfgLen,
  input  logic         cfgType,
  input  logic         start,
  output ctrlStrobes_t strb,
  output burstLen_e    curLen,
  output burstOrd_e    curOrd,
  output logic         active,
  output logic         lastBeat
);
  logic [BEAT_W-1:0] remain;
  logic accept;

  assign accept    = start && !active;
  assign strb.load = accept;
  assign strb.step = active;
  assign lastBeat  = active && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      curLen <= LEN2;
      curOrd <= ORD_SEQ;
    end else if (cfgWe && !active) begin
      curLen <= burstLen_e'(cfgLen);
      curOrd <= burstOrd_e'(cfgType);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      remain <= '0;
    end else if (accept) begin
      active <= 1'b1;
      remain <= lenMask(curLen);
    end else if (active) begin
      if (remain == '0) active <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strb,
  input  burstLen_e        curLen,
  input  burstOrd_e        curOrd,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colAddr
);
  logic [COL_W-1:0]  baseCol;
  burstLen_e         burstLen;
  burstOrd_e         burstOrd;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] mask;
  logic [BEAT_W-1:0] startOff;
  logic [BEAT_W-1:0] seqOff;
  logic [BEAT_W-1:0] xorOff;
  logic [BEAT_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseCol  <= '0;
      burstLen <= LEN2;
      burstOrd <= ORD_SEQ;
      beat     <= '0;
    end else if (strb.load) begin
      baseCol  <= startCol;
      burstLen <= curLen;
      burstOrd <= curOrd;
      beat     <= '0;
    end else if (strb.step) begin
      beat <= beat + 1'b1;
    end
  end

  assign mask     = lenMask(burstLen);
  assign startOff = baseCol[BEAT_W-1:0];
  assign seqOff   = startOff + beat;
  assign xorOff   = startOff ^ beat;

  always_comb begin
    for (int b = 0; b < BEAT_W; b++) begin
      if (mask[b]) lowBits[b] = (burstOrd == ORD_XOR) ? xorOff[b] : seqOff[b];
      else         lowBits[b] = startOff[b];
    end
  end

  generate
    if (COL_W > BEAT_W) begin : g_wide
      assign colAddr = {baseCol[COL_W-1:BEAT_W], lowBits};
    end else begin : g_narrow
      assign colAddr = lowBits[COL_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWe,
  input  logic [1:0]       cfgLen,
  input  logic             cfgType,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  output logic             busy,
  output logic             colValid,
  output logic [COL_W-1:0] colAddr,
  output logic             colLast
);
  ctrlStrobes_t strb;
  burstLen_e    curLen;
  burstOrd_e    curOrd;
  logic         active;
  logic         lastBeat;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgLen(cfgLen), .cfgType(cfgType),
    .start(start), .strb(strb), .curLen(curLen), .curOrd(curOrd),
    .active(active), .lastBeat(lastBeat)
  );

  burst_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .curLen(curLen), .curOrd(curOrd),
    .startCol(startCol), .colAddr(colAddr)
  );

  assign busy     = active;
  assign colValid = active;
  assign colLast  = lastBeat;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             cfgWe,
  input logic [1:0]       cfgLen,
  input logic             cfgType,
  input logic             start,
  input logic [COL_W-1:0] startCol,
  input logic             busy,
  input logic             colValid,
  input logic [COL_W-1:0] colAddr,
  input logic             colLast
);
  logic [4:0] runLen;

  always_ff @(posedge clk) begin
    if (rst || !colValid) runLen <= '0;
    else if (runLen != 5'd31) runLen <= runLen + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !colValid && !colLast));

  // R2
  start_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> colValid);

  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    colValid |-> (runLen < 5'd16));

  // R3
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    colLast |-> colValid);

  // R3
  last_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
    (colValid && colLast) |=> !colValid);

  // R7
  no_early_end_chk: assert property (@(posedge clk) disable iff (rst)
    (colValid && !colLast) |=> colValid);

  // R6
  upper_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (colValid && !colLast) |=> $stable(colAddr[COL_W-1:4]));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W = 14;

  logic             clk = 1'b0;
  logic             rst;
  logic             cfgWe;
  logic [1:0]       cfgLen;
  logic             cfgType;
  logic             start;
  logic [COL_W-1:0] startCol;
  logic             busy;
  logic             colValid;
  logic [COL_W-1:0] colAddr;
  logic             colLast;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgLen(cfgLen), .cfgType(cfgType),
    .start(start), .startCol(startCol), .busy(busy), .colValid(colValid),
    .colAddr(colAddr), .colLast(colLast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expAddr(input int bl, input bit ilv, input int col, input int i);
    int m;
    int lo;
    m  = bl - 1;
    lo = col & m;
    lo = ilv ? (lo ^ i) : ((lo + i) & m);
    return (col & ~m) | lo;
  endfunction

  task automatic writeCfg(input logic [1:0] len, input logic typ);
    @(negedge clk);
    cfgWe = 1; cfgLen = len; cfgType = typ;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic pulseStart(input int col);
    startCol = col[COL_W-1:0];
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // Called at the negedge after the start edge; disturb injects start/cfg at beat 2.
  task automatic checkBurst(input int bl, input bit ilv, input int col, input string req,
                            input bit disturb);
    for (int i = 0; i < bl; i++) begin
      int e;
      e = expAddr(bl, ilv, col, i);
      check(colValid === 1'b1 && busy === 1'b1, "R2", int'(colValid), 1);
      check(colAddr === e[COL_W-1:0], req, int'(colAddr), e);
      check(colLast === (i == bl - 1), "R3", int'(colLast), int'(i == bl - 1));
      check(colAddr[COL_W-1:4] === col[COL_W-1:4], "R6", int'(colAddr[COL_W-1:4]), col >> 4);
      if (disturb && i == 2) begin
        start = 1; startCol = 14'h0003;
        cfgWe = 1; cfgLen = 2'b00; cfgType = 1;
      end else begin
        start = 0; cfgWe = 0;
      end
      @(negedge clk);
    end
    start = 0; cfgWe = 0;
    check(colValid === 1'b0 && colLast === 1'b0, "R2", int'(colValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; cfgWe = 0; cfgLen = 0; cfgType = 0; start = 0; startCol = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && colValid === 1'b0 && colLast === 1'b0, "R1", int'(busy), 0);
    rst = 0;
    @(negedge clk);
    // R1 defaults: BL2 sequential
    pulseStart(14'h1235);
    checkBurst(2, 0, 14'h1235, "R1", 0);

    // R10 R4 R5 full sweep
    for (int l = 0; l < 4; l++) begin
      for (int t = 0; t < 2; t++) begin
        writeCfg(l[1:0], t[0]);
        for (int s = 0; s < 16; s++) begin
          int col;
          col = ($urandom & 14'h3FF0) | s;
          pulseStart(col);
          checkBurst(2 << l, t[0], col, t ? "R5" : "R4", 0);
          @(negedge clk);
        end
      end
    end

    // R7 R8 disturbances during a BL8 sequential burst
    writeCfg(2'b10, 0);
    pulseStart(14'h0A5D);
    checkBurst(8, 0, 14'h0A5D, "R7", 1);
    @(negedge clk);
    pulseStart(14'h0132);
    checkBurst(8, 0, 14'h0132, "R8", 0);

    // R9 cfg write and start in the same idle cycle
    @(negedge clk);
    cfgWe = 1; cfgLen = 2'b01; cfgType = 1;
    pulseStart(14'h0346);
    cfgWe = 0;
    checkBurst(8, 0, 14'h0346, "R9", 0);
    @(negedge clk);
    pulseStart(14'h0346);
    checkBurst(4, 1, 14'h0346, "R9", 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule